// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the slave side of a two-wire serial bus placed in front of an 8K x 8 byte array. A fast system clock samples the bus clock and data lines through a two-stage synchroniser. The block finds start and stop conditions and checks the first byte of every transfer against a fixed device-type code and three pin-strapped select bits, so up to eight such slaves can share one bus. It answers a matching address by pulling the data line low through an open-drain enable. The array is reached through a plain synchronous port: one read strobe returns data on the next cycle, and one write strobe stores a byte.

A write carries two address bytes and then data bytes. The data bytes collect in a 32-byte sector buffer, and the offset wraps inside the sector. On the closing stop, a program phase writes only the buffered bytes to the array. A fixed busy interval then stands in for the self-timed program cycle, and during it the slave ignores its own address so the master can poll. An internal address counter survives between transfers. A read without an address therefore continues after the last byte touched. A write that carries only the address, followed by a repeated start in read direction, gives a random read. Each byte the master acknowledges is followed by the next one, and the counter wraps from the top of the array to zero.

States: `ST_IDLE`, `ST_DEVADDR`, `ST_DEV_ACK`, `ST_ADDR_HI`, `ST_HI_ACK`, `ST_ADDR_LO`, `ST_LO_ACK`, `ST_WR_DATA`, `ST_WR_ACK`, `ST_RD_DATA`, `ST_RD_ACK`, `ST_WAIT_STOP`, `ST_PROGRAM`.

Transitions:
- A start from any state except `ST_PROGRAM` goes to `ST_DEVADDR`.
- A stop goes to `ST_PROGRAM` if data bytes are pending, and to `ST_IDLE` otherwise.
- `ST_DEVADDR` goes to `ST_DEV_ACK` on a match while not busy, and to `ST_WAIT_STOP` otherwise.
- `ST_DEV_ACK` goes to `ST_RD_DATA` (read) or `ST_ADDR_HI` (write).
- The write path runs `ST_ADDR_HI` -> `ST_HI_ACK` -> `ST_ADDR_LO` -> `ST_LO_ACK` -> `ST_WR_DATA`, then alternates `ST_WR_DATA` <-> `ST_WR_ACK`.
- The read path runs `ST_RD_DATA` -> `ST_RD_ACK`. From `ST_RD_ACK` it returns to `ST_RD_DATA` on a master acknowledge, or goes to `ST_WAIT_STOP` on a missing one.
- `ST_PROGRAM` goes to `ST_IDLE` after 32 cycles.

Top module: `twi_flash_slave`

## Requirements
- R1: While reset is low and after it is released, the slave does not pull SDA (sda_drive_low=0) and makes no array access, and it waits in idle for a start.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high, both seen after two synchroniser stages. A stop at any point abandons the transfer, releases SDA and returns to idle.
- R3: The address byte is bits[7:4]=4'b1010 (device type), bits[3:1]=dev_sel and bit0=direction (1 = read). On a mismatch the slave gives no acknowledge and stays silent until the next start or stop.
- R4: The slave acknowledges a matching address, both address bytes and every written data byte by pulling SDA low for the ninth clock. It changes SDA only while SCL is low.
- R5: The byte address is sent high byte first. Only the low 5 bits of the first byte are used (the top 3 are ignored), and the second byte gives address bits 7..0.
- R6: Written bytes are buffered in a 32-byte sector, and the low 5 address bits wrap inside the sector. A stop after at least one data byte writes exactly the received bytes, one array write each.
- R7: An address-only write followed by a repeated start and a read address returns the byte at that address. An address-only write programs nothing.
- R8: Each byte the master acknowledges is followed by the byte at the next address, and the address 8191 is followed by 0.
- R9: A read with no address phase returns the byte after the last one read or written.
- R10: After a byte that the master does not acknowledge, the slave stops driving SDA and sends nothing more until the next start or stop.
- R11: After a program phase, the slave ignores its address (no acknowledge) for BUSY_CYCLES clocks and then answers again.
- R12: mem_rdata is taken one cycle after mem_rd_en, and a read strobe and a write strobe are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| dev_sel | input | 3 | Strapped select bits compared with address bits 3..1 |
| sda_drive_low | output | 1 | Open-drain enable: 1 pulls SDA low |
| mem_addr | output | ADDR_W | Array address |
| mem_rd_en | output | 1 | Array read strobe |
| mem_rdata | input | 8 | Array read data, valid the cycle after mem_rd_en |
| mem_wr_en | output | 1 | Array write strobe |
| mem_wdata | output | 8 | Array write data |

## Verification
The checker watches five properties on every cycle. The slave never starts pulling SDA while SCL is high. A stop always leaves SDA released. The read and write strobes never overlap. Each array read advances the address counter by exactly one, modulo the array size. While the busy interval runs, the slave neither pulls SDA nor writes to the array. Only the bench's bus scenarios can show the rest: the data returned by random, current-address and sequential reads, the bytes that land in the array after a sector write that wraps, the number of array writes per transfer, and the polling answer during and after the busy interval.

// File: rtl/twi_flash_pkg.sv
package twi_flash_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_DEV_ACK,
        ST_ADDR_HI,
        ST_HI_ACK,
        ST_ADDR_LO,
        ST_LO_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_WAIT_STOP,
        ST_PROGRAM
    } twi_state_e;

    // device-type code expected in the upper nibble of the address byte
    localparam logic [3:0] DEV_TYPE_CODE = 4'b1010;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    // stages 0..SYNC_STAGES-1 synchronise, the last one holds the previous value
    logic [SYNC_STAGES:0] scl_pipe;
    logic [SYNC_STAGES:0] sda_pipe;
    logic                 scl_prev;
    logic                 sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-1:0], scl_in};
            sda_pipe <= {sda_pipe[SYNC_STAGES-1:0], sda_in};
        end
    end

    assign scl_s    = scl_pipe[SYNC_STAGES-1];
    assign sda_s    = sda_pipe[SYNC_STAGES-1];
    assign scl_prev = scl_pipe[SYNC_STAGES];
    assign sda_prev = sda_pipe[SYNC_STAGES];

    assign scl_rise  = scl_s & ~scl_prev;
    assign scl_fall  = ~scl_s & scl_prev;
    assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
    assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/twi_sector_buf.sv
module twi_sector_buf #(
    parameter int SECT_W = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [SECT_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SECT_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int SECT_BYTES = 1 << SECT_W;

    logic [DATA_W-1:0]     store [SECT_BYTES];
    logic [SECT_BYTES-1:0] filled;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filled <= '0;
        end else if (clr) begin
            filled <= '0;
        end else if (wr_en) begin
            filled[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_idx] <= wr_data;
        end
    end

    assign rd_data  = store[rd_idx];
    assign rd_valid = filled[rd_idx];

endmodule

// File: rtl/twi_busy_timer.sv
module twi_busy_timer #(
    parameter int CYCLES = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (start) begin
            remain <= CW'(CYCLES);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy = (remain != '0);

endmodule

// File: rtl/twi_flash_slave.sv
module twi_flash_slave
    import twi_flash_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int SECT_W      = 5,
    parameter int BUSY_CYCLES = 1500,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [2:0]        dev_sel,
    output logic              sda_drive_low,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    input  logic [7:0]        mem_rdata,
    output logic              mem_wr_en,
    output logic [7:0]        mem_wdata
);
    localparam int HI_W       = ADDR_W - 8;
    localparam int BASE_W     = ADDR_W - SECT_W;
    localparam int SECT_BYTES = 1 << SECT_W;

    // synchronised bus events
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    twi_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    twi_state_e st, st_nx;

    logic [7:0]        shreg;
    logic [3:0]        bit_cnt;
    logic              rw_q;
    logic              mst_ack;
    logic [7:0]        tx_sh;
    logic              rd_pend;
    logic [HI_W-1:0]   hi_q;
    logic [ADDR_W-1:0] addr_cnt;
    logic [BASE_W-1:0] sect_base;
    logic              have_data;
    logic [SECT_W:0]   prog_idx;

    logic              byte_end;
    logic              addr_ok;
    logic              prog_done;
    logic [ADDR_W-1:0] new_addr;
    logic              busy_q;

    logic              buf_wr, buf_clr, buf_valid;
    logic [7:0]        buf_rd;

    assign byte_end  = scl_fall && (bit_cnt == 4'd8);
    assign addr_ok   = (shreg[7:4] == DEV_TYPE_CODE) && (shreg[3:1] == dev_sel) && !busy_q;
    assign prog_done = (prog_idx == (SECT_W+1)'(SECT_BYTES));
    assign new_addr  = {hi_q, shreg};
    assign buf_wr    = (st == ST_WR_DATA) && byte_end;
    assign buf_clr   = (st == ST_ADDR_LO) && byte_end;

    twi_sector_buf #(.SECT_W(SECT_W), .DATA_W(8)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (buf_clr),
        .wr_en    (buf_wr),
        .wr_idx   (addr_cnt[SECT_W-1:0]),
        .wr_data  (shreg),
        .rd_idx   (prog_idx[SECT_W-1:0]),
        .rd_data  (buf_rd),
        .rd_valid (buf_valid)
    );

    twi_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .start ((st == ST_PROGRAM) && prog_done),
        .busy  (busy_q)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // next-state logic
    always_comb begin
        st_nx = st;
        if (st == ST_PROGRAM) begin
            if (prog_done) begin
                st_nx = ST_IDLE;
            end
        end else if (stop_det) begin
            st_nx = have_data ? ST_PROGRAM : ST_IDLE;
        end else if (start_det) begin
            st_nx = ST_DEVADDR;
        end else begin
            unique case (st)
                ST_IDLE, ST_WAIT_STOP, ST_PROGRAM: st_nx = st;
                ST_DEVADDR: if (byte_end) st_nx = addr_ok ? ST_DEV_ACK : ST_WAIT_STOP;
                ST_DEV_ACK: if (scl_fall) st_nx = rw_q ? ST_RD_DATA : ST_ADDR_HI;
                ST_ADDR_HI: if (byte_end) st_nx = ST_HI_ACK;
                ST_HI_ACK:  if (scl_fall) st_nx = ST_ADDR_LO;
                ST_ADDR_LO: if (byte_end) st_nx = ST_LO_ACK;
                ST_LO_ACK:  if (scl_fall) st_nx = ST_WR_DATA;
                ST_WR_DATA: if (byte_end) st_nx = ST_WR_ACK;
                ST_WR_ACK:  if (scl_fall) st_nx = ST_WR_DATA;
                ST_RD_DATA: if (byte_end) st_nx = ST_RD_ACK;
                ST_RD_ACK:  if (scl_fall) st_nx = mst_ack ? ST_RD_DATA : ST_WAIT_STOP;
                default:    st_nx = ST_IDLE;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_drive_low <= 1'b0;
            mem_addr      <= '0;
            mem_rd_en     <= 1'b0;
            mem_wr_en     <= 1'b0;
            mem_wdata     <= '0;
            shreg         <= '0;
            bit_cnt       <= '0;
            rw_q          <= 1'b0;
            mst_ack       <= 1'b0;
            tx_sh         <= '1;
            rd_pend       <= 1'b0;
            hi_q          <= '0;
            addr_cnt      <= '0;
            sect_base     <= '0;
            have_data     <= 1'b0;
            prog_idx      <= '0;
        end else begin
            mem_rd_en <= 1'b0;
            mem_wr_en <= 1'b0;
            rd_pend   <= mem_rd_en;
            if (rd_pend) begin
                tx_sh <= mem_rdata;
            end

            if (st == ST_PROGRAM) begin
                if (!prog_done) begin
                    prog_idx <= prog_idx + 1'b1;
                    if (buf_valid) begin
                        mem_wr_en <= 1'b1;
                        mem_addr  <= {sect_base, prog_idx[SECT_W-1:0]};
                        mem_wdata <= buf_rd;
                    end
                end else begin
                    have_data <= 1'b0;
                end
            end else if (stop_det) begin
                sda_drive_low <= 1'b0;
                bit_cnt       <= '0;
                prog_idx      <= '0;
            end else if (start_det) begin
                sda_drive_low <= 1'b0;
                bit_cnt       <= '0;
                have_data     <= 1'b0;
            end else begin
                unique case (st)
                    ST_DEVADDR, ST_ADDR_HI, ST_ADDR_LO, ST_WR_DATA: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[6:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (byte_end) begin
                            bit_cnt <= '0;
                            if (st == ST_DEVADDR) begin
                                if (addr_ok) begin
                                    sda_drive_low <= 1'b1;
                                    rw_q          <= shreg[0];
                                    if (shreg[0]) begin
                                        mem_rd_en <= 1'b1;
                                        mem_addr  <= addr_cnt;
                                        addr_cnt  <= addr_cnt + 1'b1;
                                    end
                                end
                            end else if (st == ST_ADDR_HI) begin
                                sda_drive_low <= 1'b1;
                                hi_q          <= shreg[HI_W-1:0];
                            end else if (st == ST_ADDR_LO) begin
                                sda_drive_low <= 1'b1;
                                addr_cnt      <= new_addr;
                                sect_base     <= new_addr[ADDR_W-1:SECT_W];
                            end else begin
                                sda_drive_low <= 1'b1;
                                have_data     <= 1'b1;
                                addr_cnt      <= {addr_cnt[ADDR_W-1:SECT_W],
                                                  addr_cnt[SECT_W-1:0] + 1'b1};
                            end
                        end
                    end
                    ST_DEV_ACK, ST_HI_ACK, ST_LO_ACK, ST_WR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt       <= '0;
                            sda_drive_low <= (st == ST_DEV_ACK) && rw_q && !tx_sh[7];
                        end
                    end
                    ST_RD_DATA: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (byte_end) begin
                            bit_cnt       <= '0;
                            sda_drive_low <= 1'b0;
                        end else if (scl_fall) begin
                            sda_drive_low <= !tx_sh[6];
                            tx_sh         <= {tx_sh[6:0], 1'b1};
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            mst_ack <= !sda_s;
                            if (!sda_s) begin
                                mem_rd_en <= 1'b1;
                                mem_addr  <= addr_cnt;
                                addr_cnt  <= addr_cnt + 1'b1;
                            end
                        end else if (scl_fall) begin
                            bit_cnt       <= '0;
                            sda_drive_low <= mst_ack && !tx_sh[7];
                        end
                    end
                    ST_IDLE, ST_WAIT_STOP, ST_PROGRAM: begin
                        sda_drive_low <= 1'b0;
                    end
                    default: sda_drive_low <= 1'b0;
                endcase
            end
        end
    end

endmodule

// File: rtl/twi_flash_slave_chk.sv
module twi_flash_slave_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_in,
    input logic              sda_drive_low,
    input logic              mem_wr_en,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] addr_cnt,
    input logic              busy,
    input logic              stop_det
);
    // R4
    sda_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_in && $past(scl_in)) |-> !$rose(sda_drive_low));

    // R2
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_det) |-> !sda_drive_low);

    // R12
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_wr_en, mem_rd_en}));

    // R8
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (addr_cnt == ADDR_W'(mem_addr + 1'b1)));

    // R11
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!sda_drive_low && !mem_wr_en));

endmodule

bind twi_flash_slave twi_flash_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_in        (scl_in),
    .sda_drive_low (sda_drive_low),
    .mem_wr_en     (mem_wr_en),
    .mem_rd_en     (mem_rd_en),
    .mem_addr      (mem_addr),
    .addr_cnt      (addr_cnt),
    .busy          (busy_q),
    .stop_det      (stop_det)
);

// File: tb/twi_flash_slave_test.sv
module twi_flash_slave_test;
    localparam int Q  = 8;
    localparam int AW = 13;
    localparam int NV = 8;
    // each vector: {address[12:0], data[7:0]}
    localparam logic [20:0] VEC [NV] = '{
        {13'h0000, 8'h5A}, {13'h1FFF, 8'hC3}, {13'h0421, 8'h00}, {13'h0ABC, 8'hFF},
        {13'h1000, 8'h81}, {13'h07FF, 8'h3C}, {13'h15E0, 8'h96}, {13'h0C3F, 8'h17}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          m_scl = 1'b1;
    logic          m_sda = 1'b1;
    logic [2:0]    sel = 3'b101;
    logic          sda_drive_low;
    logic          sda_line;
    logic [AW-1:0] mem_addr;
    logic          mem_rd_en, mem_wr_en;
    logic [7:0]    mem_rdata, mem_wdata;

    logic [7:0] bmem [1 << AW];
    logic [7:0] emem [1 << AW];
    logic [7:0] wbuf [32];
    logic [7:0] rbuf [32];
    int n_cmp = 0, n_bad = 0;
    int wr_pulses = 0, clash = 0, drive_cnt = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;
    assign sda_line = m_sda & ~sda_drive_low;

    twi_flash_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line), .dev_sel(sel),
        .sda_drive_low(sda_drive_low), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
        .mem_rdata(mem_rdata), .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) ^ (i >> 7));
    endfunction

    // array model: synchronous read with one cycle of latency (R12)
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < (1 << AW); i++) bmem[i] <= pat(i);
        end else begin
            if (mem_wr_en) begin
                bmem[mem_addr] <= mem_wdata;
                wr_pulses++;
            end
            if (mem_rd_en) mem_rdata <= bmem[mem_addr];
            if (mem_wr_en && mem_rd_en) clash++;
            if (sda_drive_low) drive_cnt++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(Q);
            m_scl = 1'b1; tick(2 * Q);
            m_scl = 1'b0; tick(Q);
        end
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        acked = (sda_line == 1'b0);
        tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic give_ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; tick(Q);
            m_scl = 1'b1; tick(Q);
            b[i] = sda_line;
            tick(Q);
            m_scl = 1'b0; tick(Q);
        end
        m_sda = give_ack ? 1'b0 : 1'b1; tick(Q);
        m_scl = 1'b1; tick(2 * Q);
        m_scl = 1'b0; tick(Q);
        m_sda = 1'b1;
    endtask

    task automatic addr_phase(input logic [AW-1:0] a, input logic [2:0] junk, output logic ok);
        logic k0, k1, k2;
        bus_start();
        send_byte({4'hA, sel, 1'b0}, k0);
        send_byte({junk, a[12:8]}, k1);
        send_byte(a[7:0], k2);
        ok = k0 & k1 & k2;
    endtask

    task automatic write_seq(input logic [AW-1:0] a, input int n, input logic [2:0] junk, output logic ok);
        logic k;
        addr_phase(a, junk, ok);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], k);
            ok = ok & k;
            emem[{a[12:5], 5'(a[4:0] + 5'(i))}] = wbuf[i];
        end
        bus_stop();
    endtask

    task automatic rand_read(input logic [AW-1:0] a, input int n, output logic ok);
        logic k;
        addr_phase(a, 3'b000, ok);
        bus_start();
        send_byte({4'hA, sel, 1'b1}, k);
        ok = ok & k;
        for (int i = 0; i < n; i++) recv_byte(rbuf[i], i != n - 1);
        bus_stop();
    endtask

    task automatic cur_read(input int n, output logic ok);
        bus_start();
        send_byte({4'hA, sel, 1'b1}, ok);
        for (int i = 0; i < n; i++) recv_byte(rbuf[i], i != n - 1);
        bus_stop();
    endtask

    task automatic poll_once(output logic ok);
        bus_start();
        send_byte({4'hA, sel, 1'b0}, ok);
        bus_stop();
    endtask

    task automatic wait_ready(output logic ok);
        ok = 1'b0;
        for (int t = 0; t < 20 && !ok; t++) poll_once(ok);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got %0h expected %0h", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic ok, k;
        logic [7:0] b;
        int w0, d0;
        logic [AW-1:0] base;

        for (int i = 0; i < (1 << AW); i++) emem[i] = pat(i);

        // R1: reset state
        tick(5);
        chk("R1 sda idle in reset", sda_drive_low, 0);
        chk("R1 no access in reset", {mem_wr_en, mem_rd_en}, 0);
        rst_n = 1'b1;
        tick(10);
        chk("R1 sda idle after reset", sda_drive_low, 0);
        chk("R1 no write after reset", wr_pulses, 0);

        // table walk: single-byte write, poll, random read (R5 R6 R7 R4)
        for (int v = 0; v < NV; v++) begin
            logic [AW-1:0] a;
            a = VEC[v][20:8];
            wbuf[0] = VEC[v][7:0];
            w0 = wr_pulses;
            write_seq(a, 1, (v % 2 == 1) ? 3'b111 : 3'b000, ok);
            chk("R4 acks on write", ok, 1);
            wait_ready(ok);
            chk("R11 ready after busy", ok, 1);
            chk("R6 one write per byte", wr_pulses - w0, 1);
            rand_read(a, 1, ok);
            chk("R7 random read ack", ok, 1);
            chk("R5 R7 readback", rbuf[0], VEC[v][7:0]);
        end

        // R11: polling during busy
        wbuf[0] = 8'hE7;
        write_seq(13'h0777, 1, 3'b000, ok);
        d0 = drive_cnt;
        poll_once(k);
        chk("R11 nack while busy", k, 0);
        chk("R11 no drive while busy", drive_cnt - d0, 0);
        wait_ready(ok);
        chk("R11 answers after busy", ok, 1);

        // R6: sector wrap of a four-byte write starting at offset 30
        base = 13'h0A40;
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        w0 = wr_pulses;
        write_seq(base + 13'd30, 4, 3'b000, ok);
        wait_ready(ok);
        chk("R6 written bytes count", wr_pulses - w0, 4);
        rand_read(base + 13'd30, 3, ok);
        chk("R6 offset 30", rbuf[0], 8'h11);
        chk("R6 offset 31", rbuf[1], 8'h22);
        chk("R8 next sector untouched", rbuf[2], emem[base + 13'd32]);
        rand_read(base, 2, ok);
        chk("R6 wrapped offset 0", rbuf[0], 8'h33);
        chk("R6 wrapped offset 1", rbuf[1], 8'h44);

        // R9: current-address reads
        rand_read(13'h0123, 1, ok);
        cur_read(1, ok);
        chk("R9 current read n+1", rbuf[0], emem[13'h0124]);
        cur_read(2, ok);
        chk("R9 continues n+2", rbuf[0], emem[13'h0125]);
        chk("R8 sequential n+3", rbuf[1], emem[13'h0126]);

        // R8: wrap at the top of the array
        rand_read(13'h1FFF, 3, ok);
        chk("R8 top byte", rbuf[0], emem[13'h1FFF]);
        chk("R8 wrap to 0", rbuf[1], emem[13'h0000]);
        chk("R8 then 1", rbuf[2], emem[13'h0001]);

        // R3: wrong select bits and wrong device type
        w0 = wr_pulses;
        bus_start();
        send_byte({4'hA, 3'b011, 1'b0}, k);
        chk("R3 wrong select nack", k, 0);
        send_byte(8'h00, k);
        send_byte(8'h10, k);
        send_byte(8'hAA, k);
        chk("R3 silent after mismatch", k, 0);
        bus_stop();
        bus_start();
        send_byte({4'hB, sel, 1'b1}, k);
        chk("R3 wrong type nack", k, 0);
        bus_stop();
        tick(100);
        chk("R3 nothing programmed", wr_pulses - w0, 0);

        // R7: address-only write programs nothing
        w0 = wr_pulses;
        addr_phase(13'h0300, 3'b000, ok);
        bus_stop();
        tick(100);
        chk("R7 address-only no write", wr_pulses - w0, 0);
        cur_read(1, ok);
        chk("R7 counter set by address", rbuf[0], emem[13'h0300]);

        // R10: nack ends the read
        addr_phase(13'h0200, 3'b000, ok);
        bus_start();
        send_byte({4'hA, sel, 1'b1}, k);
        recv_byte(b, 1'b0);
        chk("R10 byte before nack", b, emem[13'h0200]);
        d0 = drive_cnt;
        recv_byte(b, 1'b0);
        chk("R10 bus released", b, 8'hFF);
        chk("R10 no drive after nack", drive_cnt - d0, 0);
        bus_stop();

        // R2: stop in the middle of an address phase
        w0 = wr_pulses;
        bus_start();
        send_byte({4'hA, sel, 1'b0}, k);
        send_byte(8'h05, k);
        bus_stop();
        chk("R2 released after stop", sda_drive_low, 0);
        tick(100);
        chk("R2 abandoned no write", wr_pulses - w0, 0);
        rand_read(13'h0555, 1, ok);
        chk("R2 next transfer works", rbuf[0], emem[13'h0555]);

        // R12: strobes never collide
        chk("R12 no read/write overlap", clash, 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule